// File: doc/BRIEF.md
# NAND Erase-Block Bad-Mark Checker

This block decides whether one erase block of a raw NAND device carries the factory bad-block mark. A single `start` pulse supplies a block number, a two-bit device kind and the page size in bytes. The block works out the first page of the erase block from these inputs. It then drives a byte-wide NAND command/address/data bus through the read sequence that suits the device kind. It waits for a new ready edge from the device, reads one byte of the spare area, closes the read and releases chip enable.

The result is reported with a one-clock `done` pulse. Three flags are valid in that cycle and stay held until the next start: block bad, device kind unsupported, and ready wait timed out. Bus pin timing, page data movement and ECC are left to the surrounding controller. Each bus write is a one-clock `nand_wr` strobe, with `nand_cle` marking a command byte and `nand_ale` marking an address byte. A read is a one-clock `nand_rd` strobe, and `nand_din` is sampled on the following clock. `nand_rb` is high when the device is ready and is taken to be synchronous to `clk`.

Top module: `nand_badblk_chk`

## Requirements
- R1: The first page of the block equals the block number shifted left by 5 for kind 2'b00 (small page), by 6 for kind 2'b01 (large page) and by 7 for kind 2'b10 (multi-level cell).
- R2: For kind 2'b00 the first bus write is command byte 0x50, followed by exactly one address byte equal to (page size + 5) mod 16.
- R3: For kinds 2'b01 and 2'b10 the first bus write is command byte 0x00, followed by two address bytes equal to the page size, low byte first.
- R4: After the column byte(s) come three address bytes carrying the page number, least significant byte first.
- R5: Kinds 2'b01 and 2'b10 add command byte 0x30 after the last address byte; kind 2'b00 goes straight to waiting with no confirm command.
- R6: Only after ready is seen does the block issue exactly one read strobe, then command byte 0x00, and then raise chip enable (high in the `done` cycle).
- R7: `blk_bad` is 1 when the byte read is anything other than 0xFF and 0 when it is 0xFF.
- R8: Kind 2'b11 is unsupported: `done` arrives with `err_unsup` set, and no bus write, no read and no chip-enable assertion take place.
- R9: The ready-edge record is cleared when a check starts, so a `nand_rb` level already high without a fresh low-to-high edge does not end the wait.
- R10: If no ready edge is recorded within `tmo_limit` cycles of waiting, the check ends with `err_tmo` set, with no read strobe and no closing command. If the edge is recorded on the last allowed cycle, the read still proceeds.
- R11: `done` lasts exactly one clock, and at most one of `blk_bad`, `err_unsup` and `err_tmo` is set in that cycle.
- R12: Write and read strobes appear only while chip enable is low, never together, and command and address qualifiers are never both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-clock request to check a block; ignored while a check runs |
| blk_num | input | BLK_W | Erase block number |
| dev_kind | input | 2 | 00 small page, 01 large page, 10 multi-level cell, 11 unsupported |
| page_size | input | PS_W | Main-area page size in bytes |
| tmo_limit | input | TO_W | Largest number of cycles spent waiting for ready |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Current write is a command byte |
| nand_ale | output | 1 | Current write is an address byte |
| nand_wr | output | 1 | One-clock write strobe for `nand_dout` |
| nand_rd | output | 1 | One-clock read strobe |
| nand_dout | output | 8 | Byte written to the device |
| nand_din | input | 8 | Byte from the device, valid the clock after `nand_rd` |
| nand_rb | input | 1 | Device ready (1) or busy (0) |
| done | output | 1 | One-clock completion pulse |
| blk_bad | output | 1 | Block carries a bad mark |
| err_unsup | output | 1 | Device kind was unsupported |
| err_tmo | output | 1 | Ready was not seen in time |

## Verification
The two functions that can land in the same cycle are the recorded ready edge and the timeout limit, on the final permitted wait cycle. The bench sets the limit to one cycle and raises `nand_rb` in the cycle that carries the last address or confirm byte, so the edge is recorded exactly as the single wait cycle runs. It then repeats the run with the edge one cycle later. The first run must give a normal read with no timeout flag. The second must give `err_tmo`, no read strobe and no closing command.

// File: rtl/nbb_pkg.sv
package nbb_pkg;

  typedef enum logic [1:0] {
    DEV_SMALL = 2'b00,
    DEV_LARGE = 2'b01,
    DEV_MLC   = 2'b10,
    DEV_NONE  = 2'b11
  } dev_kind_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_CMD,
    S_COL0,
    S_COL1,
    S_ROW,
    S_CONF,
    S_WAIT,
    S_RD,
    S_CAP,
    S_END,
    S_FIN
  } seq_st_e;

  localparam logic [7:0] OP_SPARE_RD = 8'h50;
  localparam logic [7:0] OP_READ     = 8'h00;
  localparam logic [7:0] OP_CONFIRM  = 8'h30;
  localparam logic [7:0] MARK_CLEAN  = 8'hFF;

  function automatic logic [2:0] page_shift(input dev_kind_e k);
    case (k)
      DEV_SMALL: page_shift = 3'd5;
      DEV_LARGE: page_shift = 3'd6;
      DEV_MLC:   page_shift = 3'd7;
      default:   page_shift = 3'd0;
    endcase
  endfunction

  function automatic logic kind_ok(input dev_kind_e k);
    kind_ok = (k != DEV_NONE);
  endfunction

endpackage

// File: rtl/nbb_addr_gen.sv
module nbb_addr_gen
  import nbb_pkg::*;
#(
  parameter int BLK_W     = 16,
  parameter int PS_W      = 13,
  parameter int ROW_BYTES = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load,
  input  logic [BLK_W-1:0]            blk_i,
  input  logic [1:0]                  kind_i,
  input  logic [PS_W-1:0]             psz_i,
  output logic [7:0]                  op_first,
  output logic [7:0]                  col_lo,
  output logic [7:0]                  col_hi,
  output logic                        two_col,
  output logic                        need_conf,
  output logic [ROW_BYTES-1:0][7:0]   row_b
);

  localparam int PG_W = ROW_BYTES * 8;

  logic [BLK_W-1:0] blk_q;
  dev_kind_e        kind_q;
  logic [PS_W-1:0]  psz_q;

  logic [PG_W-1:0]  blk_ext;
  logic [PG_W-1:0]  page;
  logic [3:0]       col_small;
  logic [15:0]      psz16;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q  <= '0;
      kind_q <= DEV_SMALL;
      psz_q  <= '0;
    end else if (load) begin
      blk_q  <= blk_i;
      kind_q <= dev_kind_e'(kind_i);
      psz_q  <= psz_i;
    end
  end

  always_comb begin
    blk_ext   = {{(PG_W-BLK_W){1'b0}}, blk_q};
    page      = blk_ext << page_shift(kind_q);
    col_small = psz_q[3:0] + 4'd5;
    psz16     = 16'(psz_q);
    two_col   = (kind_q != DEV_SMALL);
    need_conf = (kind_q != DEV_SMALL);
    op_first  = two_col ? OP_READ : OP_SPARE_RD;
    col_lo    = two_col ? psz16[7:0] : {4'b0000, col_small};
    col_hi    = psz16[15:8];
  end

  for (genvar g = 0; g < ROW_BYTES; g++) begin : g_row
    assign row_b[g] = page[g*8 +: 8];
  end

  AST_PAGE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_q == DEV_MLC) |-> (row_b[0][6:0] == 7'd0)); // R1

endmodule

// File: rtl/nbb_wait_ctl.sv
module nbb_wait_ctl #(
  parameter int TO_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            rb_i,
  input  logic            cnt_en,
  input  logic [TO_W-1:0] limit,
  output logic            rdy_seen,
  output logic            tmo_hit
);

  logic            rb_q, rb_q_n;
  logic            flag_q, flag_n;
  logic [TO_W-1:0] cnt_q, cnt_n;
  logic            rise;

  always_comb begin
    rise   = rb_i & ~rb_q;
    rb_q_n = rb_i;
    if (clr)       flag_n = 1'b0;
    else if (rise) flag_n = 1'b1;
    else           flag_n = flag_q;
    cnt_n   = cnt_en ? (cnt_q + 1'b1) : '0;
    tmo_hit = cnt_en && !flag_q &&
              (({1'b0, cnt_q} + 1'b1) >= {1'b0, limit});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rb_q   <= 1'b1;
      flag_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      rb_q   <= rb_q_n;
      flag_q <= flag_n;
      cnt_q  <= cnt_n;
    end
  end

  assign rdy_seen = flag_q;

  AST_EDGE_RECORDED: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_i && !rb_q && !clr) |=> rdy_seen); // R9
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !rdy_seen); // R9
  AST_WAIT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && limit != '0) |-> (cnt_q < limit)); // R10

endmodule

// File: rtl/nbb_seq.sv
module nbb_seq
  import nbb_pkg::*;
#(
  parameter int ROW_BYTES = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [1:0]                kind_i,
  input  logic [7:0]                op_first,
  input  logic [7:0]                col_lo,
  input  logic [7:0]                col_hi,
  input  logic                      two_col,
  input  logic                      need_conf,
  input  logic [ROW_BYTES-1:0][7:0] row_b,
  input  logic                      rdy_seen,
  input  logic                      tmo_hit,
  input  logic [7:0]                din,
  output logic                      load,
  output logic                      clr,
  output logic                      cnt_en,
  output logic                      ce_n,
  output logic                      cle,
  output logic                      ale,
  output logic                      wr,
  output logic                      rd,
  output logic [7:0]                dout,
  output logic                      done,
  output logic                      bad,
  output logic                      err_unsup,
  output logic                      err_tmo
);

  localparam int RI_W = (ROW_BYTES > 1) ? $clog2(ROW_BYTES) : 1;

  seq_st_e   st_q, st_n;
  logic [RI_W-1:0] ri_q, ri_n;
  logic      bad_q, bad_n;
  logic      uns_q, uns_n;
  logic      tmo_q, tmo_n;
  logic      accept;
  logic      kind_good;

  assign kind_good = kind_ok(dev_kind_e'(kind_i));
  assign accept    = (st_q == S_IDLE) && start;

  // next state
  always_comb begin
    st_n = st_q;
    case (st_q)
      S_IDLE: if (start) st_n = kind_good ? S_CMD : S_FIN;
      S_CMD:  st_n = S_COL0;
      S_COL0: st_n = two_col ? S_COL1 : S_ROW;
      S_COL1: st_n = S_ROW;
      S_ROW:  if (ri_q == RI_W'(ROW_BYTES - 1)) st_n = need_conf ? S_CONF : S_WAIT;
      S_CONF: st_n = S_WAIT;
      S_WAIT: begin
        if (rdy_seen)     st_n = S_RD;
        else if (tmo_hit) st_n = S_FIN;
      end
      S_RD:   st_n = S_CAP;
      S_CAP:  st_n = S_END;
      S_END:  st_n = S_FIN;
      S_FIN:  st_n = S_IDLE;
      default: st_n = S_IDLE;
    endcase
    ri_n = (st_q == S_ROW) ? (ri_q + 1'b1) : '0;
  end

  // result next values
  always_comb begin
    bad_n = bad_q;
    uns_n = uns_q;
    tmo_n = tmo_q;
    if (accept) begin
      bad_n = 1'b0;
      uns_n = !kind_good;
      tmo_n = 1'b0;
    end else begin
      if (st_q == S_CAP) bad_n = (din != MARK_CLEAN);
      if (st_q == S_WAIT && !rdy_seen && tmo_hit) tmo_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      ri_q  <= '0;
      bad_q <= 1'b0;
      uns_q <= 1'b0;
      tmo_q <= 1'b0;
    end else begin
      st_q  <= st_n;
      ri_q  <= ri_n;
      bad_q <= bad_n;
      uns_q <= uns_n;
      tmo_q <= tmo_n;
    end
  end

  // bus decode from state
  always_comb begin
    cle  = (st_q == S_CMD) || (st_q == S_CONF) || (st_q == S_END);
    ale  = (st_q == S_COL0) || (st_q == S_COL1) || (st_q == S_ROW);
    wr   = cle || ale;
    rd   = (st_q == S_RD);
    ce_n = (st_q == S_IDLE) || (st_q == S_FIN);
    case (st_q)
      S_CMD:   dout = op_first;
      S_COL0:  dout = col_lo;
      S_COL1:  dout = col_hi;
      S_ROW:   dout = row_b[ri_q];
      S_CONF:  dout = OP_CONFIRM;
      default: dout = OP_READ;
    endcase
  end

  assign load      = accept;
  assign clr       = accept;
  assign cnt_en    = (st_q == S_WAIT);
  assign done      = (st_q == S_FIN);
  assign bad       = bad_q;
  assign err_unsup = uns_q;
  assign err_tmo   = tmo_q;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11
  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($countones({bad, err_unsup, err_tmo}) <= 1)); // R11
  AST_STROBE_UNDER_CE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr || rd) |-> !ce_n); // R12
  AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr, rd})); // R12
  AST_QUAL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle && ale)); // R12
  AST_READ_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    rd |-> $past(rdy_seen)); // R6
  AST_UNSUP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err_unsup) |-> ($past(st_q) == S_IDLE)); // R8
  AST_TMO_FROM_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err_tmo) |-> ($past(st_q) == S_WAIT)); // R10

endmodule

// File: rtl/nand_badblk_chk.sv
module nand_badblk_chk
  import nbb_pkg::*;
#(
  parameter int BLK_W = 16,
  parameter int PS_W  = 13,
  parameter int TO_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [BLK_W-1:0] blk_num,
  input  logic [1:0]       dev_kind,
  input  logic [PS_W-1:0]  page_size,
  input  logic [TO_W-1:0]  tmo_limit,
  output logic             nand_ce_n,
  output logic             nand_cle,
  output logic             nand_ale,
  output logic             nand_wr,
  output logic             nand_rd,
  output logic [7:0]       nand_dout,
  input  logic [7:0]       nand_din,
  input  logic             nand_rb,
  output logic             done,
  output logic             blk_bad,
  output logic             err_unsup,
  output logic             err_tmo
);

  localparam int ROW_BYTES = 3;

  logic       rst_m, rst_s;
  logic       load, clr, cnt_en;
  logic [7:0] op_first, col_lo, col_hi;
  logic       two_col, need_conf;
  logic [ROW_BYTES-1:0][7:0] row_b;
  logic       rdy_seen, tmo_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  nbb_addr_gen #(.BLK_W(BLK_W), .PS_W(PS_W), .ROW_BYTES(ROW_BYTES)) u_addr (
    .clk(clk), .rst_n(rst_s), .load(load), .blk_i(blk_num), .kind_i(dev_kind),
    .psz_i(page_size), .op_first(op_first), .col_lo(col_lo), .col_hi(col_hi),
    .two_col(two_col), .need_conf(need_conf), .row_b(row_b)
  );

  nbb_wait_ctl #(.TO_W(TO_W)) u_wait (
    .clk(clk), .rst_n(rst_s), .clr(clr), .rb_i(nand_rb), .cnt_en(cnt_en),
    .limit(tmo_limit), .rdy_seen(rdy_seen), .tmo_hit(tmo_hit)
  );

  nbb_seq #(.ROW_BYTES(ROW_BYTES)) u_seq (
    .clk(clk), .rst_n(rst_s), .start(start), .kind_i(dev_kind),
    .op_first(op_first), .col_lo(col_lo), .col_hi(col_hi), .two_col(two_col),
    .need_conf(need_conf), .row_b(row_b), .rdy_seen(rdy_seen), .tmo_hit(tmo_hit),
    .din(nand_din), .load(load), .clr(clr), .cnt_en(cnt_en), .ce_n(nand_ce_n),
    .cle(nand_cle), .ale(nand_ale), .wr(nand_wr), .rd(nand_rd), .dout(nand_dout),
    .done(done), .bad(blk_bad), .err_unsup(err_unsup), .err_tmo(err_tmo)
  );

endmodule

// File: tb/nand_badblk_chk_tb.sv
`timescale 1ns/1ps
module nand_badblk_chk_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] blk_num = '0;
  logic [1:0]  dev_kind = '0;
  logic [12:0] page_size = '0;
  logic [15:0] tmo_limit = 16'd50;
  logic [7:0]  nand_din = 8'hFF;
  logic        nand_rb = 1'b1;
  logic        nand_ce_n, nand_cle, nand_ale, nand_wr, nand_rd;
  logic [7:0]  nand_dout;
  logic        done, blk_bad, err_unsup, err_tmo;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  nand_badblk_chk u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .blk_num(blk_num),
    .dev_kind(dev_kind), .page_size(page_size), .tmo_limit(tmo_limit),
    .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_wr(nand_wr), .nand_rd(nand_rd), .nand_dout(nand_dout),
    .nand_din(nand_din), .nand_rb(nand_rb), .done(done), .blk_bad(blk_bad),
    .err_unsup(err_unsup), .err_tmo(err_tmo)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // mode: 0 normal read, 1 unsupported, 2 timeout expected
  // rb_mode: 0 busy pulse ending 'delay' cycles after last write, 1 stays high
  task automatic run_op(input logic [1:0] kind, input logic [15:0] blk,
                        input logic [12:0] ps, input logic [15:0] tmo,
                        input logic [7:0] spare, input int rb_mode,
                        input int delay, input int mode, input string tag);
    logic [7:0]  eb [16];
    bit          ec [16];
    string       er [16];
    logic [7:0]  gb [16];
    bit          gc [16];
    bit          ga [16];
    logic [23:0] pg;
    int n_pre, n_tot, wcnt, rcnt, ccnt, rd_pos, dcnt, cyc;
    bit rb_up, seen;
    n_pre = 0;
    pg = {8'h00, blk} << ((kind == 2'b00) ? 5 : (kind == 2'b01) ? 6 : 7);
    if (kind == 2'b00) begin
      eb[0] = 8'h50; ec[0] = 1; er[0] = "R2";
      eb[1] = {4'h0, 4'(ps[3:0] + 4'd5)}; ec[1] = 0; er[1] = "R2";
      n_pre = 2;
    end else begin
      eb[0] = 8'h00; ec[0] = 1; er[0] = "R3";
      eb[1] = ps[7:0]; ec[1] = 0; er[1] = "R3";
      eb[2] = {3'b000, ps[12:8]}; ec[2] = 0; er[2] = "R3";
      n_pre = 3;
    end
    for (int i = 0; i < 3; i++) begin
      eb[n_pre] = pg[i*8 +: 8]; ec[n_pre] = 0; er[n_pre] = "R4 R1";
      n_pre++;
    end
    if (kind != 2'b00) begin
      eb[n_pre] = 8'h30; ec[n_pre] = 1; er[n_pre] = "R5";
      n_pre++;
    end
    eb[n_pre] = 8'h00; ec[n_pre] = 1; er[n_pre] = "R6";
    n_tot = (mode == 0) ? n_pre + 1 : (mode == 2) ? n_pre : 0;

    @(negedge clk);
    blk_num = blk; dev_kind = kind; page_size = ps; tmo_limit = tmo;
    nand_din = spare; start = 1'b1;
    if (rb_mode == 0) nand_rb = 1'b0;
    wcnt = 0; rcnt = 0; ccnt = 0; rd_pos = -1; dcnt = 0; rb_up = 0; seen = 0;
    for (cyc = 0; cyc < 3000; cyc++) begin
      @(negedge clk);
      start = 1'b0;
      if (!nand_ce_n) ccnt++;
      if (nand_rd) begin rcnt++; rd_pos = wcnt; end
      if (nand_wr) begin
        if (wcnt < 16) begin gb[wcnt] = nand_dout; gc[wcnt] = nand_cle; ga[wcnt] = nand_ale; end
        wcnt++;
      end
      if (rb_mode == 0 && !rb_up && wcnt >= n_pre) begin
        if (dcnt == delay) begin nand_rb = 1'b1; rb_up = 1; end
        else dcnt++;
      end
      if (done) begin seen = 1; break; end
    end
    chk(seen, "R11", {tag, " done seen (watchdog)"}, seen, 1);
    if (seen) begin
      chk(nand_ce_n == 1'b1, "R6", {tag, " CE released at done"}, nand_ce_n, 1);
      chk(wcnt == n_tot, (mode == 1) ? "R8" : (mode == 2) ? "R10" : "R5 R6",
          {tag, " write count"}, wcnt, n_tot);
      for (int i = 0; i < n_tot && i < wcnt && i < 16; i++)
        chk(gb[i] == eb[i] && gc[i] == ec[i] && ga[i] == !ec[i], er[i],
            $sformatf("%s byte %0d", tag, i), {gc[i], ga[i], gb[i]}, {ec[i], !ec[i], eb[i]});
      if (mode == 0) begin
        chk(rcnt == 1 && rd_pos == n_pre, "R6", {tag, " one read after address"}, rd_pos, n_pre);
        chk(blk_bad == (spare != 8'hFF), "R7", {tag, " bad flag"}, blk_bad, spare != 8'hFF);
        chk(!err_tmo && !err_unsup, "R10", {tag, " no error flags"}, {err_unsup, err_tmo}, 0);
      end else if (mode == 1) begin
        chk(err_unsup && !blk_bad && !err_tmo, "R8", {tag, " unsupported flag"},
            {blk_bad, err_unsup, err_tmo}, 3'b010);
        chk(ccnt == 0 && rcnt == 0, "R8", {tag, " no CE and no read"}, ccnt + rcnt, 0);
      end else begin
        chk(err_tmo && !blk_bad && !err_unsup, "R10", {tag, " timeout flag"},
            {blk_bad, err_unsup, err_tmo}, 3'b001);
        chk(rcnt == 0, "R10", {tag, " no read on timeout"}, rcnt, 0);
      end
      @(negedge clk);
      chk(done == 1'b0, "R11", {tag, " done one cycle"}, done, 0);
      chk(blk_bad == (mode == 0 && spare != 8'hFF), "R11", {tag, " flag held"}, blk_bad,
          mode == 0 && spare != 8'hFF);
    end
    nand_rb = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(nand_ce_n && !nand_wr && !nand_rd && !done, "R12", "reset idle bus",
        {nand_ce_n, nand_wr, nand_rd, done}, 4'b1000);
    chk(!blk_bad && !err_unsup && !err_tmo, "R11", "reset flags", {blk_bad, err_unsup, err_tmo}, 0);
  endtask

  task automatic t_small();
    run_op(2'b00, 16'd3, 13'd512, 16'd50, 8'hFF, 0, 3, 0, "small good");
    run_op(2'b00, 16'h0ABC, 13'd520, 16'd50, 8'h00, 0, 2, 0, "small bad col D");
  endtask

  task automatic t_large();
    run_op(2'b01, 16'h1234, 13'd2048, 16'd50, 8'h00, 0, 4, 0, "large bad");
    run_op(2'b01, 16'h0001, 13'd2112, 16'd50, 8'hFF, 0, 1, 0, "large good");
  endtask

  task automatic t_mlc();
    run_op(2'b10, 16'h0205, 13'd4096, 16'd50, 8'hFE, 0, 3, 0, "mlc bad");
    run_op(2'b10, 16'hFFFF, 13'd4096, 16'd50, 8'hFF, 0, 0, 0, "mlc good top block");
  endtask

  task automatic t_unsup();
    run_op(2'b11, 16'h0042, 13'd2048, 16'd50, 8'h00, 1, 0, 1, "unsupported");
  endtask

  task automatic t_stale_ready();
    run_op(2'b01, 16'h0010, 13'd2048, 16'd20, 8'h00, 1, 0, 2, "R9 stale ready");
  endtask

  task automatic t_race();
    run_op(2'b01, 16'h0007, 13'd2048, 16'd1, 8'h00, 0, 0, 0, "R10 edge on last wait cycle");
    run_op(2'b01, 16'h0007, 13'd2048, 16'd1, 8'h00, 0, 1, 2, "R10 edge one cycle late");
    run_op(2'b00, 16'h0007, 13'd512, 16'd1, 8'hFF, 0, 0, 0, "R10 small edge on limit");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_small();
    t_large();
    t_mlc();
    t_unsup();
    t_stale_ready();
    t_race();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule